// File: doc/BRIEF.md
# Fractional Accumulator Clock Divider

This block derives a slower clock enable and a square wave from a fast system clock when the wanted division ratio is not a whole number. The ratio arrives as an unsigned fixed-point tuning word. The upper `INT_W` bits hold the integer part and the lower `FRAC_W` bits hold the fraction. The tuning word is the system clock frequency divided by the wanted output frequency. Every output period is a whole number of system cycles. A fractional remainder is carried from one period to the next, so consecutive periods alternate between the floor and the ceiling of the ratio. Over many periods the average frequency matches the fixed-point ratio.

Typical use: with a 50 MHz system clock and a target of about 3.372 MHz, software sets 8 fraction bits and a tuning word of 3796 (14.828125). The block then produces periods of 14, 15, 15, … cycles, which averages about 3.37197 MHz. A tuning word with a zero fraction gives a plain integer divider. For example, 12500.0 turns 50 MHz into a 4 kHz tick. More fraction bits give a smaller frequency error.

Top module: `frac_accum_div`

## Requirements
- R1: Counting from the first enabled cycle (t = 0), the k-th period (k ≥ 1) ends after cycle floor(k·W / 2^FRAC_W) − 1, where W is the tuning word after clamping. This means each period length is floor(r + W) in fixed point, where r is the fraction carried from the previous period and starts at zero.
- R2: With FRAC_W = 8 and tuning word 0xED4 (14.828125), the first three periods last 14, 15 and 15 cycles, and exactly 256 ticks occur in the first 3796 enabled cycles.
- R3: A tuning word whose fraction bits are all zero gives every period the same length, equal to its integer part.
- R4: An integer part of 0 or 1 is treated as 2, and the fraction bits are kept.
- R5: `tick_o` is high for exactly one cycle, on the last cycle of each period.
- R6: In a period of length N, `sq_o` is high for the first floor(N/2) cycles and low for the rest.
- R7: `tune_i` is sampled only on the last cycle of a period, and it sets the next period. A change made inside a period does not alter that period's length.
- R8: While `en_i` is low, both outputs are low, the carried fraction is cleared, and the block reloads from the present `tune_i`. The first cycle with `en_i` high is cycle 0 of a fresh first period.
- R9: While `rst_ni` is low, and for the first cycle after its release, both outputs are low. The clock edge at the end of that cycle loads the tuning word, and the next cycle is cycle 0 of a fresh first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the divider idle and reloading |
| tune_i | input | INT_W+FRAC_W | Fixed-point tuning word (integer.fraction) |
| tick_o | output | 1 | One-cycle pulse on the last cycle of each output period |
| sq_o | output | 1 | Square wave, high for the first half of each period |

## Verification
A corrupted carried fraction does not change the current period. It shows up on the next boundary as a tick that comes one cycle early or late, so the cumulative-boundary comparison exposes it within one period. A wrong period length or position shifts `sq_o`'s falling edge or the tick inside the same period. Because the expected boundaries are computed from the absolute product k·W, a fault is never masked by later periods: once it occurs, every following tick stays misaligned.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;
    // Smallest period the divider will produce, in system cycles.
    localparam int unsigned MIN_DIV = 2;

    // LOAD: state is (re)loaded from the tuning word; RUN: periods are counted.
    typedef enum logic [0:0] {
        MODE_LOAD = 1'b0,
        MODE_RUN  = 1'b1
    } fdiv_mode_e;
endpackage

// File: rtl/fdiv_step.sv
`timescale 1ns/1ps
// Computes the length of the next period and the fraction it leaves behind.
module fdiv_step #(
    parameter int unsigned INT_W  = 16,
    parameter int unsigned FRAC_W = 8
) (
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic [INT_W+FRAC_W-1:0] tune_i,
    output logic [INT_W:0]          len_o,
    output logic [FRAC_W-1:0]       frac_o
);
    import fdiv_pkg::*;

    localparam int unsigned TW    = INT_W + FRAC_W;
    localparam int unsigned LEN_W = INT_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [FRAC_W-1:0] frac;
    } step_t;

    step_t             res_d;
    logic [INT_W-1:0]  whole;
    logic [INT_W-1:0]  whole_c;
    logic [FRAC_W:0]   part_sum;

    always_comb begin
        whole    = tune_i[TW-1:FRAC_W];
        whole_c  = (whole < INT_W'(MIN_DIV)) ? INT_W'(MIN_DIV) : whole;
        part_sum = {1'b0, frac_i} + {1'b0, tune_i[FRAC_W-1:0]};
        res_d.len  = {1'b0, whole_c} + LEN_W'(part_sum[FRAC_W]);
        res_d.frac = part_sum[FRAC_W-1:0];
    end

    assign len_o  = res_d.len;
    assign frac_o = res_d.frac;
endmodule

// File: rtl/fdiv_phase.sv
`timescale 1ns/1ps
// Holds the period position, the current length and the carried fraction.
module fdiv_phase #(
    parameter int unsigned INT_W  = 16,
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [INT_W:0]    nlen_i,
    input  logic [FRAC_W-1:0] nfrac_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic              tick_o,
    output logic              sq_o
);
    import fdiv_pkg::*;

    localparam int unsigned LEN_W = INT_W + 1;

    typedef struct packed {
        fdiv_mode_e        mode;
        logic [LEN_W-1:0]  pos;
        logic [LEN_W-1:0]  len;
        logic [FRAC_W-1:0] frac;
    } phase_t;

    phase_t st_d, st_q;
    logic   run;
    logic   last;

    always_comb begin
        run    = en_i && (st_q.mode == MODE_RUN);
        last   = (st_q.pos == st_q.len - LEN_W'(1));
        frac_o = run ? st_q.frac : '0;
        tick_o = run && last;
        sq_o   = run && (st_q.pos < (st_q.len >> 1));

        st_d      = st_q;
        st_d.mode = MODE_RUN;
        if (!run || last) begin
            st_d.pos  = '0;
            st_d.len  = nlen_i;
            st_d.frac = nfrac_i;
        end else begin
            st_d.pos  = st_q.pos + LEN_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode <= MODE_LOAD;
            st_q.pos  <= '0;
            st_q.len  <= LEN_W'(MIN_DIV);
            st_q.frac <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_len_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.len >= LEN_W'(MIN_DIV));

    assert_pos_inside_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pos < st_q.len);

    assert_tick_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    assert_sq_opens_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (!en_i || sq_o));

    assert_sq_low_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> !sq_o);

    assert_len_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && st_q.mode == MODE_RUN && !tick_o) |=> $stable(st_q.len));

    assert_idle_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (st_q.pos == '0));
endmodule

// File: rtl/frac_accum_div.sv
`timescale 1ns/1ps
module frac_accum_div #(
    parameter int unsigned INT_W  = 16,
    parameter int unsigned FRAC_W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    en_i,
    input  logic [INT_W+FRAC_W-1:0] tune_i,
    output logic                    tick_o,
    output logic                    sq_o
);
    logic [FRAC_W-1:0] carry_frac;
    logic [INT_W:0]    next_len;
    logic [FRAC_W-1:0] next_frac;

    fdiv_step #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_step (
        .frac_i (carry_frac),
        .tune_i (tune_i),
        .len_o  (next_len),
        .frac_o (next_frac)
    );

    fdiv_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .nlen_i  (next_len),
        .nfrac_i (next_frac),
        .frac_o  (carry_frac),
        .tick_o  (tick_o),
        .sq_o    (sq_o)
    );
endmodule

// File: tb/frac_accum_div_bench.sv
`timescale 1ns/1ps
module frac_accum_div_bench;
    localparam int SI = 6;
    localparam int SF = 4;
    localparam int LI = 16;
    localparam int LF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_s = 1'b0;
    logic [SI+SF-1:0] word_s = '0;
    logic tick_s, sq_s;
    logic en_w = 1'b0;
    logic [LI+LF-1:0] word_w = '0;
    logic tick_w, sq_w;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    frac_accum_div #(.INT_W(SI), .FRAC_W(SF)) u_frac_accum_div (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_s), .tune_i(word_s),
        .tick_o(tick_s), .sq_o(sq_s));

    frac_accum_div #(.INT_W(LI), .FRAC_W(LF)) u_frac_accum_div_w (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_w), .tune_i(word_w),
        .tick_o(tick_w), .sq_o(sq_w));

    // Expected {tick, sq} at enabled cycle t for word w with fb fraction bits.
    function automatic logic [1:0] exp_out(longint w, int fb, longint t);
        longint ip = w >> fb;
        longint fm = w & ((longint'(1) << fb) - 1);
        longint wc = (ip < 2) ? ((longint'(2) << fb) | fm) : w;
        longint k = 1;
        longint prev = 0;
        longint cur = (k * wc) >> fb;
        longint len;
        while (cur <= t) begin
            prev = cur;
            k++;
            cur = (k * wc) >> fb;
        end
        len = cur - prev;
        exp_out = {(t == cur - 1), ((t - prev) < (len / 2))};
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(150000 * 4);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int ticks;
        logic [1:0] e;
        string rt, rs;

        // R9: outputs low during reset even with enable high
        en_s = 1'b1;
        word_s = 10'd80;
        repeat (2) begin
            @(negedge clk); #1;
            check("R9 tick in reset", tick_s, 1'b0);
            check("R9 sq in reset", sq_s, 1'b0);
        end
        @(negedge clk); rst_n = 1'b1; #1;
        check("R9 tick load cycle", tick_s, 1'b0);
        check("R9 sq load cycle", sq_s, 1'b0);
        for (int t = 0; t < 10; t++) begin
            @(negedge clk); #1;
            e = exp_out(80, SF, t);
            check("R9 tick after release", tick_s, e[1]);
            check("R9 sq after release", sq_s, e[0]);
        end

        // R7: word change mid-period applies only from the next boundary
        @(negedge clk); en_s = 1'b0; word_s = 10'd80; #1;
        check("R8 tick idle", tick_s, 1'b0);
        for (int t = 0; t < 15; t++) begin
            @(negedge clk);
            en_s = 1'b1;
            if (t == 2) word_s = 10'd144;
            #1;
            check("R7 tick timing", tick_s, (t == 4 || t == 13));
        end

        // Sweep every small-config word: R1 R3 R4 R5 R6 R8
        for (int w = 0; w < 1024; w++) begin
            @(negedge clk); en_s = 1'b0; word_s = w[9:0]; #1;
            check("R8 tick low when disabled", tick_s, 1'b0);
            check("R8 sq low when disabled", sq_s, 1'b0);
            @(negedge clk); #1;
            check("R8 tick low when disabled", tick_s, 1'b0);
            check("R8 sq low when disabled", sq_s, 1'b0);
            if ((w >> SF) < 2) begin rt = "R4 R5 tick"; rs = "R4 R6 sq"; end
            else if ((w % 16) == 0) begin rt = "R3 R5 tick"; rs = "R3 R6 sq"; end
            else begin rt = "R1 R5 tick"; rs = "R1 R6 sq"; end
            for (int t = 0; t < 48; t++) begin
                @(negedge clk); en_s = 1'b1; #1;
                e = exp_out(w, SF, t);
                check(rt, tick_s, e[1]);
                check(rs, sq_s, e[0]);
            end
        end
        @(negedge clk); en_s = 1'b0;

        // R2: 14.828125 with 8 fraction bits
        word_w = 24'hED4;
        @(negedge clk);
        ticks = 0;
        for (int t = 0; t < 3796; t++) begin
            @(negedge clk); en_w = 1'b1; #1;
            if (tick_w) ticks++;
            if (t < 45) check("R2 tick at 13/28/43", tick_w, (t == 13 || t == 28 || t == 43));
            e = exp_out(24'hED4, LF, t);
            check("R1 R5 wide tick", tick_w, e[1]);
            check("R6 wide sq", sq_w, e[0]);
        end
        checks++;
        if (ticks != 256) begin
            fails++;
            $display("FAIL R2 tick count: actual %0d expected 256", ticks);
        end

        summary();
        $finish;
    end
endmodule